// File: doc/BRIEF.md
# Video Lock Status Hysteresis Filter

This block turns a noisy raw lock indication from a video decoder front end into a stable locked/unlocked flag. A raw lock condition is formed from a horizontal-lock input. It can also take in a field-based vertical lock evaluation and a subcarrier-lock input. The block samples that condition once per video line, on a line strobe. The filtered flag changes only after the raw condition has disagreed with it for a programmable number of consecutive lines.

Two separate 3-bit codes set the number of lines needed to enter lock and to leave lock. Both codes use the same non-linear table. This lets a system acquire lock quickly and drop it reluctantly, or the other way round. A one-cycle change pulse marks every transition of the filtered flag.

Top module: `vlh_lock_filter`

## Requirements
- R1: After reset `lock_o` is 0 and `chg_o` is 0.
- R2: While unlocked, `lock_o` rises on the line strobe where the raw condition has been 1 for N consecutive strobes. N comes from `in_code_i` by this table: 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000.
- R3: While locked, `lock_o` falls on the line strobe where the raw condition has been 0 for N consecutive strobes. N comes from `out_code_i` by the same table as R2.
- R4: A strobed line on which the raw condition equals `lock_o` restarts the consecutive-line count from zero.
- R5: Clock cycles without `line_i` high neither change `lock_o` nor advance the count.
- R6: With `raw_sel_i`=1 (line-by-line mode) and `sc_en_i`=0, the raw condition is `h_lock_i`.
- R7: With `raw_sel_i`=0 (field mode), the raw condition additionally requires `v_lock_i`=1.
- R8: With `sc_en_i`=1, the raw condition additionally requires `sc_lock_i`=1.
- R9: `chg_o` is high for exactly the one cycle in which `lock_o` shows a new value, and is low otherwise.
- R10: A new count code is used from the next line strobe. Changing a code does not alter `lock_o` by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | One-cycle strobe per video line |
| h_lock_i | input | 1 | Horizontal lock from the front end |
| sc_lock_i | input | 1 | Subcarrier lock from the front end |
| v_lock_i | input | 1 | Field-based vertical lock evaluation |
| raw_sel_i | input | 1 | 0: field mode, 1: line-by-line mode |
| sc_en_i | input | 1 | 1: subcarrier lock also required |
| in_code_i | input | 3 | Count-into-lock code |
| out_code_i | input | 3 | Count-out-of-lock code |
| lock_o | output | 1 | Filtered lock status |
| chg_o | output | 1 | One-cycle pulse on each status change |

## Verification
On every cycle, the assertions check the following: the status holds between line strobes, a line that agrees with the status clears the count, `chg_o` tracks each change of the status, and the flag cannot rise while the raw condition is gated off by the subcarrier or mode qualifiers. The exact line counts from the table can only be shown by the bench's scenarios. These cover every entry threshold including 100000, and every exit threshold up to 1000. The scenarios also cover the restart of an interrupted run and the effect of a code change in the middle of a run. The reference model is compared with both outputs on every clock.

// File: rtl/vlh_pkg.sv
package vlh_pkg;
  typedef logic [2:0] code_t;

  // non-linear line-count table shared by entry and exit codes
  function automatic int unsigned code_to_lines(code_t c);
    case (c)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 5;
      3'd3:    return 10;
      3'd4:    return 100;
      3'd5:    return 500;
      3'd6:    return 1000;
      default: return 100000;
    endcase
  endfunction
endpackage

// File: rtl/vlh_raw_sel.sv
module vlh_raw_sel (
  input  logic h_lock_i,
  input  logic sc_lock_i,
  input  logic v_lock_i,
  input  logic raw_sel_i,
  input  logic sc_en_i,
  output logic raw_o
);
  logic base;
  logic sc_ok;

  always_comb begin
    base  = raw_sel_i ? h_lock_i : (h_lock_i & v_lock_i);
    sc_ok = sc_en_i ? sc_lock_i : 1'b1;
    raw_o = base & sc_ok;
  end
endmodule

// File: rtl/vlh_thresh.sv
module vlh_thresh
  import vlh_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  code_t            in_code_i,
  input  code_t            out_code_i,
  input  logic             lock_i,
  output logic [CNT_W-1:0] thr_o
);
  int unsigned sel_lines;

  always_comb begin
    sel_lines = lock_i ? code_to_lines(out_code_i) : code_to_lines(in_code_i);
    thr_o     = CNT_W'(sel_lines);
  end
endmodule

// File: rtl/vlh_counter.sv
module vlh_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             lock_o,
  output logic             chg_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;
  logic             hit;

  always_comb begin
    cnt_inc = EXT_W'(cnt_q) + EXT_W'(1);
    hit     = (cnt_inc >= EXT_W'(thr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_o <= 1'b0;
      chg_o  <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (line_i) begin
        if (raw_i != lock_o) begin
          if (hit) begin
            lock_o <= raw_i;
            chg_o  <= 1'b1;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  // R5: status only moves on a line strobe
  a_r5_hold_no_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> $stable(lock_o));

  // R4: agreeing line restarts the count
  a_r4_agree_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && (raw_i == lock_o)) |=> (cnt_q == '0) && $stable(lock_o));

  // R9: pulse exactly when status differs from the previous cycle
  a_r9_chg_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (chg_o == (lock_o != $past(lock_o))));
endmodule

// File: rtl/vlh_lock_filter.sv
module vlh_lock_filter
  import vlh_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       h_lock_i,
  input  logic       sc_lock_i,
  input  logic       v_lock_i,
  input  logic       raw_sel_i,
  input  logic       sc_en_i,
  input  logic [2:0] in_code_i,
  input  logic [2:0] out_code_i,
  output logic       lock_o,
  output logic       chg_o
);
  logic             raw;
  logic [CNT_W-1:0] thr;

  vlh_raw_sel u_raw (
    .h_lock_i  (h_lock_i),
    .sc_lock_i (sc_lock_i),
    .v_lock_i  (v_lock_i),
    .raw_sel_i (raw_sel_i),
    .sc_en_i   (sc_en_i),
    .raw_o     (raw)
  );

  vlh_thresh #(.CNT_W(CNT_W)) u_thr (
    .in_code_i  (in_code_i),
    .out_code_i (out_code_i),
    .lock_i     (lock_o),
    .thr_o      (thr)
  );

  vlh_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .raw_i  (raw),
    .thr_i  (thr),
    .lock_o (lock_o),
    .chg_o  (chg_o)
  );

  // R8: missing subcarrier lock keeps an unlocked status unlocked
  a_r8_sc_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_en_i && !sc_lock_i && !lock_o) |=> !lock_o);

  // R7: field mode without vertical lock cannot enter lock
  a_r7_field_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_sel_i && !v_lock_i && !lock_o) |=> !lock_o);

  // R6: line mode, agreeing horizontal lock holds status
  a_r6_line_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_sel_i && !sc_en_i && (h_lock_i == lock_o)) |=> $stable(lock_o));
endmodule

// File: tb/vlh_lock_filter_tb.sv
module vlh_lock_filter_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic line_i = 1'b0, h_lock_i = 1'b0, sc_lock_i = 1'b0, v_lock_i = 1'b0;
  logic raw_sel_i = 1'b1, sc_en_i = 1'b0;
  logic [2:0] in_code_i = 3'd0, out_code_i = 3'd0;
  logic lock_o, chg_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  // reference model state
  bit m_lock = 0, m_chg = 0;
  int m_cnt = 0;

  always #10 clk_i = ~clk_i;

  vlh_lock_filter u_dut (.*);

  function automatic int lines_of(int c);
    int t[8] = '{1, 2, 5, 10, 100, 500, 1000, 100000};
    return t[c];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lock = 0; m_chg = 0; m_cnt = 0;
    end else begin
      bit r;
      m_chg = 0;
      if (line_i) begin
        r = h_lock_i && (raw_sel_i || v_lock_i) && (!sc_en_i || sc_lock_i);
        if (r != m_lock) begin
          m_cnt++;
          if (m_cnt >= lines_of(m_lock ? int'(out_code_i) : int'(in_code_i))) begin
            m_lock = r; m_chg = 1; m_cnt = 0;
          end
        end else m_cnt = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_vec++;
      if (lock_o !== m_lock || chg_o !== m_chg) begin
        n_bad++;
        $display("FAIL %s model: lock=%b chg=%b expected lock=%b chg=%b",
                 tag, lock_o, chg_o, m_lock, m_chg);
      end
    end
  end

  task automatic chk(input string r, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", r, act, exp);
    end
  endtask

  // apply n cycles with the given line value, ending just after an edge
  task automatic run(input bit ln, input int n);
    for (int i = 0; i < n; i++) begin
      line_i = ln;
      @(posedge clk_i); #1;
    end
    line_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 180000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=180000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    tag = "R1";
    chk("R1 lock after reset", lock_o, 1'b0);
    chk("R1 chg after reset", chg_o, 1'b0);
    rst_ni = 1'b1;
    run(0, 2);

    // R2 / R3 full table walk in line mode
    for (int c = 0; c < 7; c++) begin
      tag = "R2";
      in_code_i = 3'(c); out_code_i = 3'(c);
      h_lock_i = 1'b1;
      run(1, lines_of(c) - 1);
      chk("R2 not yet locked", lock_o, 1'b0);
      run(1, 1);
      chk("R2 locked at threshold", lock_o, 1'b1);
      chk("R9 pulse on rise", chg_o, 1'b1);
      run(0, 1);
      chk("R9 pulse one cycle", chg_o, 1'b0);
      tag = "R3";
      h_lock_i = 1'b0;
      run(1, lines_of(c) - 1);
      chk("R3 still locked", lock_o, 1'b1);
      run(1, 1);
      chk("R3 unlocked at threshold", lock_o, 1'b0);
      chk("R9 pulse on fall", chg_o, 1'b1);
      run(0, 1);
    end

    // R4: interrupted run restarts
    tag = "R4";
    in_code_i = 3'd2;
    h_lock_i = 1'b1; run(1, 4);
    h_lock_i = 1'b0; run(1, 1);
    h_lock_i = 1'b1; run(1, 4);
    chk("R4 restart no lock", lock_o, 1'b0);
    run(1, 1);
    chk("R4 lock after fresh run", lock_o, 1'b1);

    // R5: no strobe, no effect
    tag = "R5";
    out_code_i = 3'd0;
    h_lock_i = 1'b0;
    run(0, 50);
    chk("R5 no change without line", lock_o, 1'b1);
    run(1, 1);
    chk("R5 strobe then unlock", lock_o, 1'b0);

    // R10: code change mid-run and while holding
    tag = "R10";
    in_code_i = 3'd3;
    h_lock_i = 1'b1; run(1, 4);
    in_code_i = 3'd1; run(1, 1);
    chk("R10 new code used next line", lock_o, 1'b1);
    out_code_i = 3'd6; in_code_i = 3'd7; run(0, 5);
    chk("R10 code change keeps status", lock_o, 1'b1);
    out_code_i = 3'd0; h_lock_i = 1'b0; run(1, 1);

    // R7: field mode
    tag = "R7";
    raw_sel_i = 1'b0; in_code_i = 3'd0;
    h_lock_i = 1'b1; v_lock_i = 1'b0; run(1, 3);
    chk("R7 no lock without vertical", lock_o, 1'b0);
    v_lock_i = 1'b1; run(1, 1);
    chk("R7 lock with vertical", lock_o, 1'b1);
    v_lock_i = 1'b0; run(1, 1);
    chk("R7 vertical loss unlocks", lock_o, 1'b0);

    // R8: subcarrier qualifier
    tag = "R8";
    raw_sel_i = 1'b1; sc_en_i = 1'b1; sc_lock_i = 1'b0;
    run(1, 3);
    chk("R8 no lock without subcarrier", lock_o, 1'b0);
    sc_lock_i = 1'b1; run(1, 1);
    chk("R8 lock with subcarrier", lock_o, 1'b1);
    sc_en_i = 1'b0; sc_lock_i = 1'b0; run(1, 2);
    chk("R6 h lock alone holds", lock_o, 1'b1);
    tag = "R6";
    h_lock_i = 1'b0; run(1, 1);
    chk("R6 h loss unlocks", lock_o, 1'b0);

    // R2 largest entry count
    tag = "R2";
    in_code_i = 3'd7; h_lock_i = 1'b1;
    run(1, 99999);
    chk("R2 code7 not locked at 99999", lock_o, 1'b0);
    run(1, 1);
    chk("R2 code7 locked at 100000", lock_o, 1'b1);
    run(0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule